// File: doc/BRIEF.md
# Dual Battery Fault Indicator

This block watches the failure flags of two backup batteries and turns their combined health into a pattern on one fault LED. A free-running time base gives a pulse once per second. On every SAMPLE_TICKS-th pulse the block takes one look at both failure inputs. For each battery it keeps a stored good/bad state, a warned flag, and the time since that state last changed. A battery that has stayed bad for WARN_TICKS pulses is marked as warned at the next look.

A look must not happen while the memory engine is moving data. If a look falls due while the busy input is high, it is held and taken in the first cycle the input is low. The LED mode is a two-bit code. It is rebuilt from a fixed priority only when a stored state or a warned flag changes. In between, a flip command can invert its low bit. A configuration input marks a board with no batteries. It darkens the LED and stops all looks. Each look that changes something gives a one-cycle event pulse.

Top module: `batt_fault_top`

## Requirements
- R1: Both failure inputs are sampled only on the tick that completes each group of SAMPLE_TICKS ticks, counted from reset. Between samples the stored states ignore the inputs.
- R2: A sample that finds a battery's input state (good = failure input low) different from its stored state updates the stored state and restarts that battery's failure age. A battery that becomes good has its warned flag cleared.
- R3: A sample that finds a battery still bad and not yet warned sets its warned flag if at least WARN_TICKS ticks have passed since its last change. A warned battery is always a bad battery.
- R4: On each recompute the mode takes the first match in this order: 0 (off) when both batteries are good; 1 (solid on) when either is warned; 2 (fast flash) when both are bad; 3 (slow flash) when exactly one is bad.
- R5: The mode is recomputed only on a sample that changes a stored state or warned flag, and the recompute wins over flip. Otherwise a flip_i pulse toggles bit 0 of the mode on the next edge, and the mode holds at all other times.
- R6: A sample falling due while dma_busy_i is high changes nothing and is kept pending. It is taken on the first edge at which dma_busy_i is low.
- R7: Flash timing: a 3-bit phase advances once every FLASH_DIV clocks from reset. The LED drive is 0 in mode 0 and 1 in mode 1. In mode 2 it is on during odd phases (4 of 8). In mode 3 it is on during phases 0 to 2 (3 of 8).
- R8: event_o is high for exactly the one cycle after a sample that changed any stored state or warned flag.
- R9: During reset each stored state is loaded from its failure input, both warned flags are cleared and the mode is evaluated once from those states.
- R10: While no_batt_i is high, led_mode_o reads 0, the drive is 0, no sample is taken and the sample count is held at its start. Counting resumes from zero when no_batt_i goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle time base pulse (one per second) |
| fail_i | input | 2 | Battery failure inputs, bit i high = battery i failed |
| dma_busy_i | input | 1 | Data transfer in progress; samples are deferred while high |
| no_batt_i | input | 1 | Board has no batteries: LED off, sampling stopped |
| flip_i | input | 1 | Toggle bit 0 of the stored LED mode |
| led_mode_o | output | 2 | Effective LED mode: 0 off, 1 on, 2 fast flash, 3 slow flash |
| led_drive_o | output | 1 | LED drive level |
| event_o | output | 1 | Pulse after a sample that changed state or warning |
| bat_good_o | output | 2 | Stored good state per battery |
| bat_warned_o | output | 2 | Warned flag per battery |

## Verification
The hardest case to reach from the ports is a sample that falls due in the middle of a data transfer. Its effect must appear only in the first idle cycle, and that cycle can be many ticks after the due tick. Directed stimulus holds dma_busy_i high across a due tick and checks that nothing changes before it releases the input. The long-failure warning needs a battery held bad across many sample periods, so the bench shortens WARN_TICKS and SAMPLE_TICKS through parameters. A seeded random phase then mixes ticks, busy bursts, flips, no-battery spells and resets, and compares every output each cycle against a reference model that keeps absolute change times.

// File: rtl/batt_fault_pkg.sv
package batt_fault_pkg;

    localparam int NUM_BATT = 2;
    localparam int PHASE_W  = 3;

    typedef enum logic [1:0] {
        LED_OFF  = 2'd0,
        LED_ON   = 2'd1,
        LED_FAST = 2'd2,
        LED_SLOW = 2'd3
    } led_mode_t;

    typedef struct packed {
        logic good;
        logic warned;
    } batt_state_t;

    // Priority ranking of the combined battery health
    function automatic led_mode_t pick_mode(input logic [NUM_BATT-1:0] good,
                                            input logic [NUM_BATT-1:0] warned);
        led_mode_t m;
        if (&good)
            m = LED_OFF;
        else if (|warned)
            m = LED_ON;
        else if (~|good)
            m = LED_FAST;
        else
            m = LED_SLOW;
        return m;
    endfunction

    // Drive level for a mode at a given phase of the 8-phase cycle
    function automatic logic flash_level(input led_mode_t m,
                                         input logic [PHASE_W-1:0] ph);
        logic lvl;
        case (m)
            LED_OFF:  lvl = 1'b0;
            LED_ON:   lvl = 1'b1;
            LED_FAST: lvl = ph[0];
            default:  lvl = (ph < 3'd3);
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/batt_sample_sched.sv
module batt_sample_sched #(
    parameter int SAMPLE_TICKS = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic busy_i,
    input  logic hold_i,
    output logic sample_o
);
    localparam int CNT_W = (SAMPLE_TICKS > 1) ? $clog2(SAMPLE_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_TICKS - 1);

    logic [CNT_W-1:0] tick_cnt;
    logic             pending;
    logic             due;

    assign due      = !hold_i && tick_i && (tick_cnt == CNT_LAST);
    assign sample_o = !hold_i && !busy_i && (due || pending);

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            tick_cnt <= '0;
            pending  <= 1'b0;
        end else begin
            if (tick_i)
                tick_cnt <= (tick_cnt == CNT_LAST) ? '0 : tick_cnt + 1'b1;
            pending <= busy_i && (due || pending);
        end
    end
endmodule

// File: rtl/batt_track.sv
module batt_track
    import batt_fault_pkg::*;
#(
    parameter int WARN_TICKS = 18000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        fail_i,
    input  logic        sample_i,
    output batt_state_t state_o,
    output batt_state_t nxt_o,
    output logic        changed_o
);
    localparam int AGE_W = $clog2(WARN_TICKS + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WARN_TICKS);

    batt_state_t     st;
    batt_state_t     nxt;
    logic            chg;
    logic            flipped;
    logic [AGE_W-1:0] bad_age;

    always_comb begin
        nxt     = st;
        chg     = 1'b0;
        flipped = 1'b0;
        if (sample_i) begin
            if (!fail_i != st.good) begin
                nxt.good = !fail_i;
                if (!fail_i)
                    nxt.warned = 1'b0;
                chg     = 1'b1;
                flipped = 1'b1;
            end else if (!st.good && !st.warned && (bad_age >= AGE_MAX)) begin
                nxt.warned = 1'b1;
                chg        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.good   <= !fail_i;
            st.warned <= 1'b0;
            bad_age   <= '0;
        end else begin
            st <= nxt;
            if (flipped)
                bad_age <= '0;
            else if (tick_i && !st.good && (bad_age != AGE_MAX))
                bad_age <= bad_age + 1'b1;
        end
    end

    assign state_o   = st;
    assign nxt_o     = nxt;
    assign changed_o = chg;
endmodule

// File: rtl/batt_led_pattern.sv
module batt_led_pattern
    import batt_fault_pkg::*;
#(
    parameter int FLASH_DIV = 25_000_000
) (
    input  logic      clk,
    input  logic      rst,
    input  led_mode_t mode_i,
    output logic      drive_o
);
    localparam int PRE_W = (FLASH_DIV > 1) ? $clog2(FLASH_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(FLASH_DIV - 1);

    logic [PRE_W-1:0]   pre;
    logic [PHASE_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre   <= '0;
            phase <= '0;
        end else if (pre == PRE_LAST) begin
            pre   <= '0;
            phase <= phase + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    assign drive_o = flash_level(mode_i, phase);
endmodule

// File: rtl/batt_fault_top.sv
module batt_fault_top
    import batt_fault_pkg::*;
#(
    parameter int SAMPLE_TICKS = 60,
    parameter int WARN_TICKS   = 18000,
    parameter int FLASH_DIV    = 25_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic [1:0] fail_i,
    input  logic       dma_busy_i,
    input  logic       no_batt_i,
    input  logic       flip_i,
    output logic [1:0] led_mode_o,
    output logic       led_drive_o,
    output logic       event_o,
    output logic [1:0] bat_good_o,
    output logic [1:0] bat_warned_o
);
    logic                sample;
    batt_state_t         cur  [NUM_BATT];
    batt_state_t         nxt  [NUM_BATT];
    logic [NUM_BATT-1:0] chg;
    logic [NUM_BATT-1:0] good_nxt;
    logic [NUM_BATT-1:0] warn_nxt;
    led_mode_t           mode_q;
    led_mode_t           mode_eff;
    logic                event_q;

    batt_sample_sched #(.SAMPLE_TICKS(SAMPLE_TICKS)) u_sched (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .busy_i   (dma_busy_i),
        .hold_i   (no_batt_i),
        .sample_o (sample)
    );

    for (genvar i = 0; i < NUM_BATT; i++) begin : g_batt
        batt_track #(.WARN_TICKS(WARN_TICKS)) u_track (
            .clk       (clk),
            .rst       (rst),
            .tick_i    (tick_i),
            .fail_i    (fail_i[i]),
            .sample_i  (sample),
            .state_o   (cur[i]),
            .nxt_o     (nxt[i]),
            .changed_o (chg[i])
        );
        assign good_nxt[i]     = nxt[i].good;
        assign warn_nxt[i]     = nxt[i].warned;
        assign bat_good_o[i]   = cur[i].good;
        assign bat_warned_o[i] = cur[i].warned;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= pick_mode(~fail_i, '0);
            event_q <= 1'b0;
        end else begin
            event_q <= |chg;
            if (|chg)
                mode_q <= pick_mode(good_nxt, warn_nxt);
            else if (flip_i)
                mode_q <= led_mode_t'({mode_q[1], ~mode_q[0]});
        end
    end

    assign mode_eff = no_batt_i ? LED_OFF : mode_q;

    batt_led_pattern #(.FLASH_DIV(FLASH_DIV)) u_led (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode_eff),
        .drive_o (led_drive_o)
    );

    assign led_mode_o = mode_eff;
    assign event_o    = event_q;
endmodule

// File: rtl/batt_fault_chk.sv
module batt_fault_chk (
    input logic       clk,
    input logic       rst,
    input logic       dma_busy_i,
    input logic       no_batt_i,
    input logic       flip_i,
    input logic [1:0] led_mode_o,
    input logic       led_drive_o,
    input logic       event_o,
    input logic [1:0] bat_good_o,
    input logic [1:0] bat_warned_o
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_NOBATT_DARK: assert property (@(posedge clk) disable iff (rst)
        no_batt_i |-> (led_mode_o == 2'd0 && !led_drive_o)); // R10

    AST_WARN_NEEDS_BAD: assert property (@(posedge clk) disable iff (rst)
        |bat_warned_o |-> ((bat_warned_o & bat_good_o) == 2'b00)); // R3

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
        dma_busy_i |=> ($stable(bat_good_o) && $stable(bat_warned_o))); // R6

    AST_EVENT_MARKS_CHANGE: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$stable(bat_good_o) || !$stable(bat_warned_o)) |-> event_o); // R8

    AST_ALLGOOD_OFF: assert property (@(posedge clk) disable iff (rst)
        (event_o && (&bat_good_o)) |-> (led_mode_o == 2'd0)); // R4

    AST_WARN_SOLID: assert property (@(posedge clk) disable iff (rst)
        (event_o && (|bat_warned_o) && !no_batt_i) |-> (led_mode_o == 2'd1)); // R4

    AST_MODE_STEADY: assert property (@(posedge clk) disable iff (rst || !armed)
        (!event_o && !$past(flip_i) && !no_batt_i && !$past(no_batt_i))
        |-> $stable(led_mode_o)); // R5

    AST_SOLID_LEVELS: assert property (@(posedge clk) disable iff (rst)
        (led_mode_o[1] == 1'b0) |-> (led_drive_o == led_mode_o[0])); // R7
endmodule

bind batt_fault_top batt_fault_chk u_chk (.*);

// File: tb/sim_batt_fault_top.sv
module sim_batt_fault_top;
    localparam int S = 4;
    localparam int W = 30;
    localparam int D = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] fail = 2'b01;
    logic       busy = 1'b0;
    logic       nb = 1'b0;
    logic       flip = 1'b0;
    logic [1:0] led_mode;
    logic       led_drive;
    logic       evt;
    logic [1:0] good;
    logic [1:0] warned;

    int nchk = 0;
    int nerr = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #2 clk = ~clk;

    batt_fault_top #(.SAMPLE_TICKS(S), .WARN_TICKS(W), .FLASH_DIV(D)) u0 (
        .clk(clk), .rst(rst), .tick_i(tick), .fail_i(fail),
        .dma_busy_i(busy), .no_batt_i(nb), .flip_i(flip),
        .led_mode_o(led_mode), .led_drive_o(led_drive), .event_o(evt),
        .bat_good_o(good), .bat_warned_o(warned)
    );

    // reference model state
    int         m_cnt, m_nt, m_pre, m_ph, m_mode;
    bit         m_pend, m_evt;
    logic [1:0] m_good, m_warn;
    int         m_last [2];

    function automatic int prio(input logic [1:0] g, input logic [1:0] w);
        if (g == 2'b11) return 0;
        if (w != 2'b00) return 1;
        if (g == 2'b00) return 2;
        return 3;
    endfunction

    function automatic int exp_drive(input int mode, input int ph, input bit off);
        if (off) return 0;
        case (mode)
            0: return 0;
            1: return 1;
            2: return ph % 2;
            default: return (ph < 3) ? 1 : 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_pend = 0; m_nt = 0; m_pre = 0; m_ph = 0; m_evt = 0;
            m_good = ~fail; m_warn = 2'b00;
            m_last[0] = 0; m_last[1] = 0;
            m_mode = prio(m_good, m_warn);
        end else begin
            bit due, take, chg;
            int nt_new;
            if (m_pre == D - 1) begin m_pre = 0; m_ph = (m_ph + 1) % 8; end
            else m_pre = m_pre + 1;
            due  = !nb && tick && (m_cnt == S - 1);
            take = !nb && !busy && (due || m_pend);
            m_pend = !nb && busy && (due || m_pend);
            if (nb) m_cnt = 0;
            else if (tick) m_cnt = (m_cnt == S - 1) ? 0 : m_cnt + 1;
            nt_new = m_nt + (tick ? 1 : 0);
            chg = 0;
            if (take) begin
                for (int i = 0; i < 2; i++) begin
                    if (!fail[i] != m_good[i]) begin
                        m_good[i] = !fail[i];
                        m_last[i] = nt_new;
                        if (m_good[i]) m_warn[i] = 1'b0;
                        chg = 1;
                    end else if (!m_good[i] && !m_warn[i] && (m_nt - m_last[i]) >= W) begin
                        m_warn[i] = 1'b1;
                        chg = 1;
                    end
                end
            end
            m_nt = nt_new;
            if (chg) m_mode = prio(m_good, m_warn);
            else if (flip) m_mode = m_mode ^ 1;
            m_evt = chg;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk("R2 stored good", good, m_good);
            chk("R3 warned flags", warned, m_warn);
            chk("R4/R5 led mode", led_mode, nb ? 0 : m_mode);
            chk("R7 led drive", led_drive, exp_drive(m_mode, m_ph, nb));
            chk("R8 event pulse", evt, m_evt);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int hi;
        void'($urandom(32'd1234));
        step(3);
        rst = 1'b0;
        // R9 reset loading: battery 0 failed, battery 1 good -> one bad, slow flash
        chk("R9 good after reset", good, 2'b10);
        chk("R9 warned after reset", warned, 2'b00);
        chk("R9 mode after reset", led_mode, 3);
        chk("R9 event after reset", evt, 0);
        cmp_on = 1;

        // R1 sample period
        fail = 2'b00; tick = 1'b1;
        step(3);
        chk("R1 no sample before period", good, 2'b10);
        step(1);
        chk("R1 sample at period end", good, 2'b11);
        chk("R8 event on change", evt, 1);
        chk("R4 both good off", led_mode, 0);

        // R6 defer during transfer
        fail = 2'b10; busy = 1'b1;
        step(7);
        chk("R6 no change while busy", good, 2'b11);
        tick = 1'b0; busy = 1'b0;
        step(1);
        chk("R6 pending sample taken", good, 2'b01);
        chk("R4 one bad slow flash", led_mode, 3);

        // R3 long failure warning
        tick = 1'b1;
        step(60);
        chk("R3 warned after long failure", warned, 2'b10);
        chk("R3 warned gives solid", led_mode, 1);

        // R2 recovery clears warning
        fail = 2'b00;
        step(4);
        chk("R2 recovered good", good, 2'b11);
        chk("R2 warning cleared", warned, 2'b00);

        // R5 flip
        tick = 1'b0; flip = 1'b1;
        step(1);
        flip = 1'b0;
        chk("R5 flip toggles bit0", led_mode, 1);
        step(5);
        chk("R5 mode holds", led_mode, 1);
        flip = 1'b1; step(1); flip = 1'b0;
        chk("R5 flip back", led_mode, 0);

        // R7 fast flash duty
        fail = 2'b11; tick = 1'b1;
        step(4);
        tick = 1'b0;
        chk("R7 both bad fast", led_mode, 2);
        hi = 0;
        for (int k = 0; k < 8 * D; k++) begin
            step(1);
            hi += led_drive;
        end
        chk("R7 fast flash half duty", hi, 4 * D);

        // R10 no battery configuration
        nb = 1'b1; fail = 2'b00; tick = 1'b1;
        step(12);
        chk("R10 mode forced off", led_mode, 0);
        chk("R10 drive off", led_drive, 0);
        chk("R10 sampling disabled", good, 2'b00);
        nb = 1'b0;
        step(3);
        chk("R10 count restarts", good, 2'b00);
        step(1);
        chk("R10 sampling resumed", good, 2'b11);

        // seeded random phase
        for (int c = 0; c < 4000; c++) begin
            tick = ($urandom % 3) == 0;
            if ($urandom % 40 == 0) fail[0] = ~fail[0];
            if ($urandom % 40 == 0) fail[1] = ~fail[1];
            if ($urandom % 25 == 0) busy = ~busy;
            flip = ($urandom % 60) == 0;
            if ($urandom % 300 == 0) nb = ~nb;
            rst = ($urandom % 1500) == 0;
            step(1);
        end
        rst = 1'b0; tick = 1'b0; flip = 1'b0;
        step(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule